// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block sits beside a serial audio receiver and watches three audio clocks that have already been brought into one reference clock domain: the system clock, the bit clock and the word (frame) clock. It counts system-clock rising edges between consecutive rising edges of the word clock and compares each count against twelve legal system-clock-to-sample-rate multiples. A ratio is reported only after two full frames in a row land on the same legal multiple.

Downstream logic reads the outputs to pick a clock source and to manage power. A missing system clock is flagged so that a clock can be derived from the bit clock instead. A power-save request is raised when the bit clock and the word clock have both stopped, and withdrawn when the word clock starts again.

Top module: `clk_ratio_detect`

## Requirements
- R1: The ratio code is a 4-bit index of the legal multiple in ascending order (64=0, 128=1, 192=2, 256=3, 384=4, 512=5, 768=6, 1024=7, 1152=8, 1536=9, 2048=10, 3072=11). While the valid flag is low the code reads 15.
- R2: A frame whose system-clock edge count is within 2 of a legal multiple maps to that multiple. A frame that is 3 or more away from every legal multiple maps to no multiple.
- R3: The valid flag rises only at a word-clock rising edge that closes the second of two consecutive full frames mapping to the same multiple. The partial frame after reset or after a lost clock is discarded.
- R4: At the word-clock rising edge that closes a frame mapping to a different multiple, or to none, the valid flag drops and the code returns to 15.
- R5: After HALT_LIMIT (4096) reference cycles with no system-clock edge, the missing-system-clock flag is high and the valid flag is low. The flag clears on the next system-clock edge.
- R6: The power-save request rises only when the word clock and the bit clock have both been without an edge for HALT_LIMIT reference cycles. A stopped word clock alone, with the bit clock running, does not raise it. A stopped word clock also clears the valid flag.
- R7: Once raised, the power-save request stays high through bit-clock activity and falls on the first word-clock rising edge.
- R8: While reset is asserted, the outputs read code 15 with the valid flag, the missing-system-clock flag and the power-save request all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sck_i | input | 1 | Synchronised sample of the system clock |
| bck_i | input | 1 | Synchronised sample of the bit clock |
| lrck_i | input | 1 | Synchronised sample of the word clock |
| ratio_code_o | output | 4 | Detected ratio index, 15 when invalid |
| ratio_valid_o | output | 1 | Ratio confirmed over two frames |
| sck_missing_o | output | 1 | System clock absent |
| power_save_o | output | 1 | Request to enter power-save |

## Verification
The assertions assume that every audio clock input is already a clean sample in the reference domain. Each level is held for at least one reference cycle, so a single sample step is one edge. They also assume the word clock toggles at least once every HALT_LIMIT cycles while it runs. The stimulus drives the system clock at half the reference rate and derives the word clock from whole frames with a high phase no longer than 3075 cycles. Clocks are stopped only in deliberate phases that are well past the limit, so a halt is never borderline.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int NUM_RATIO = 12;
  localparam int CODE_W    = 4;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'hF;

  localparam int CLK_SCK  = 0;
  localparam int CLK_BCK  = 1;
  localparam int CLK_LRCK = 2;
  localparam int NUM_CLK  = 3;

  function automatic int ratio_of(input int idx);
    case (idx)
      0:  ratio_of = 64;
      1:  ratio_of = 128;
      2:  ratio_of = 192;
      3:  ratio_of = 256;
      4:  ratio_of = 384;
      5:  ratio_of = 512;
      6:  ratio_of = 768;
      7:  ratio_of = 1024;
      8:  ratio_of = 1152;
      9:  ratio_of = 1536;
      10: ratio_of = 2048;
      default: ratio_of = 3072;
    endcase
  endfunction
endpackage

// File: rtl/ccd_edge_watch.sv
module ccd_edge_watch #(
  parameter int HALT_LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic edge_o,
  output logic halted_o,
  output logic gone_o
);
  localparam int QW = $clog2(HALT_LIMIT + 1);
  localparam logic [QW-1:0] QMAX = QW'(HALT_LIMIT);

  logic          prev_q;
  logic [QW-1:0] quiet_q, quiet_d;
  logic          quiet_en;

  assign edge_o   = sig_i ^ prev_q;
  assign rise_o   = sig_i & ~prev_q;
  assign halted_o = (quiet_q == QMAX);
  assign gone_o   = halted_o & ~edge_o;

  always_comb begin
    quiet_en = edge_o | (quiet_q != QMAX);
    quiet_d  = edge_o ? '0 : quiet_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      quiet_q <= '0;
    end else begin
      prev_q <= sig_i;
      if (quiet_en) quiet_q <= quiet_d;
    end
  end
endmodule

// File: rtl/ccd_ratio_match.sv
module ccd_ratio_match
  import ccd_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int EW = CNT_W + 2;

  logic [NUM_RATIO-1:0] hit;
  logic [EW-1:0]        cnt_ext;

  assign cnt_ext = {2'b00, cnt_i};

  for (genvar i = 0; i < NUM_RATIO; i++) begin : g_win
    localparam int NOM = ratio_of(i);
    localparam logic [EW-1:0] LO = EW'((NOM > TOL) ? NOM - TOL : 0);
    localparam logic [EW-1:0] HI = EW'(NOM + TOL);
    assign hit[i] = (cnt_ext >= LO) && (cnt_ext <= HI);
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int i = NUM_RATIO - 1; i >= 0; i--) begin
      if (hit[i]) code_o = CODE_W'(i);
    end
  end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import ccd_pkg::*;
#(
  parameter int HALT_LIMIT = 4096,
  parameter int CNT_W      = 13,
  parameter int TOL        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              bck_i,
  input  logic              lrck_i,
  output logic [CODE_W-1:0] ratio_code_o,
  output logic              ratio_valid_o,
  output logic              sck_missing_o,
  output logic              power_save_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CLK-1:0] clk_in, rise, edg, halted, gone;
  assign clk_in = {lrck_i, bck_i, sck_i};

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_watch
    ccd_edge_watch #(.HALT_LIMIT(HALT_LIMIT)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_i    (clk_in[c]),
      .rise_o   (rise[c]),
      .edge_o   (edg[c]),
      .halted_o (halted[c]),
      .gone_o   (gone[c])
    );
  end

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] match_code;
  logic [CODE_W-1:0] prev_q, prev_d, code_q, code_d;
  logic              armed_q, armed_d, valid_q, valid_d, ps_q, ps_d;
  logic              lost, frame_end, cnt_en;

  ccd_ratio_match #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
    .cnt_i  (cnt_q),
    .code_o (match_code)
  );

  assign lost      = gone[CLK_SCK] | gone[CLK_LRCK];
  assign frame_end = rise[CLK_LRCK];

  always_comb begin
    armed_d = armed_q;
    prev_d  = prev_q;
    valid_d = valid_q;
    code_d  = code_q;
    cnt_en  = 1'b1;
    cnt_d   = cnt_q;
    if (lost) begin
      armed_d = 1'b0;
      prev_d  = CODE_NONE;
      valid_d = 1'b0;
      code_d  = CODE_NONE;
      cnt_d   = '0;
    end else if (frame_end) begin
      cnt_d = rise[CLK_SCK] ? CNT_W'(1) : '0;
      if (!armed_q) begin
        armed_d = 1'b1;
        prev_d  = CODE_NONE;
        valid_d = 1'b0;
        code_d  = CODE_NONE;
      end else begin
        prev_d = match_code;
        if ((match_code != CODE_NONE) && (match_code == prev_q)) begin
          valid_d = 1'b1;
          code_d  = match_code;
        end else begin
          valid_d = 1'b0;
          code_d  = CODE_NONE;
        end
      end
    end else begin
      cnt_en = rise[CLK_SCK] && (cnt_q != CNT_MAX);
      cnt_d  = cnt_q + CNT_W'(1);
    end

    ps_d = ps_q;
    if (frame_end)                              ps_d = 1'b0;
    else if (halted[CLK_LRCK] && halted[CLK_BCK]) ps_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      prev_q  <= CODE_NONE;
      valid_q <= 1'b0;
      code_q  <= CODE_NONE;
      ps_q    <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      armed_q <= armed_d;
      prev_q  <= prev_d;
      valid_q <= valid_d;
      code_q  <= code_d;
      ps_q    <= ps_d;
    end
  end

  assign ratio_code_o  = code_q;
  assign ratio_valid_o = valid_q;
  assign sck_missing_o = halted[CLK_SCK];
  assign power_save_o  = ps_q;
endmodule

// File: rtl/clk_ratio_detect_chk.sv
module clk_ratio_detect_chk #(
  parameter int HALT_LIMIT = 4096
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sck_i,
  input logic       bck_i,
  input logic       lrck_i,
  input logic [3:0] ratio_code_o,
  input logic       ratio_valid_o,
  input logic       sck_missing_o,
  input logic       power_save_o
);
  logic sck_p, bck_p, lr_p;
  int   sck_quiet, bck_quiet, lr_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 1'b0; bck_p <= 1'b0; lr_p <= 1'b0;
      sck_quiet <= 0; bck_quiet <= 0; lr_quiet <= 0;
    end else begin
      sck_p <= sck_i; bck_p <= bck_i; lr_p <= lrck_i;
      sck_quiet <= (sck_i != sck_p) ? 0 : ((sck_quiet < HALT_LIMIT) ? sck_quiet + 1 : sck_quiet);
      bck_quiet <= (bck_i != bck_p) ? 0 : ((bck_quiet < HALT_LIMIT) ? bck_quiet + 1 : bck_quiet);
      lr_quiet  <= (lrck_i != lr_p) ? 0 : ((lr_quiet < HALT_LIMIT) ? lr_quiet + 1 : lr_quiet);
    end
  end

  assert_code_encoding_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid_o ? (ratio_code_o <= 4'd11) : (ratio_code_o == 4'd15));

  assert_valid_on_frame_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid_o) |-> ($past(lrck_i) && !$past(lrck_i, 2)));

  assert_missing_after_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck_missing_o |-> (sck_quiet >= HALT_LIMIT) && !ratio_valid_o);

  assert_power_save_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_save_o) |-> ($past(lr_quiet) >= HALT_LIMIT) && ($past(bck_quiet) >= HALT_LIMIT));

  assert_power_save_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_save_o) |-> ($past(lrck_i) && !$past(lrck_i, 2)));
endmodule

bind clk_ratio_detect clk_ratio_detect_chk #(.HALT_LIMIT(HALT_LIMIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sck_i         (sck_i),
  .bck_i         (bck_i),
  .lrck_i        (lrck_i),
  .ratio_code_o  (ratio_code_o),
  .ratio_valid_o (ratio_valid_o),
  .sck_missing_o (sck_missing_o),
  .power_save_o  (power_save_o)
);

// File: tb/clk_ratio_detect_bench.sv
module clk_ratio_detect_bench;
  localparam int LIMIT = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, bck = 1'b0, lrck = 1'b0;
  logic [3:0] code;
  logic valid, missing, psave;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  bit m_armed = 0;
  int m_prev = 15, m_code = 15, m_last = 0;
  bit m_valid = 0, m_ps = 0, m_miss = 0;

  always #10 clk = ~clk;

  clk_ratio_detect u_clk_ratio_detect (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .bck_i(bck), .lrck_i(lrck),
    .ratio_code_o(code), .ratio_valid_o(valid),
    .sck_missing_o(missing), .power_save_o(psave)
  );

  function automatic int legal_ratio(input int i);
    int t[12] = '{64, 128, 192, 256, 384, 512, 768, 1024, 1152, 1536, 2048, 3072};
    return t[i];
  endfunction

  function automatic int classify(input int n);
    for (int i = 0; i < 12; i++)
      if (n >= legal_ratio(i) - 2 && n <= legal_ratio(i) + 2) return i;
    return 15;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " valid"}, valid, m_valid);
    chk({tag, " code"}, code, m_code);
    chk({tag, " power_save"}, psave, m_ps);
    chk({tag, " sck_missing"}, missing, m_miss);
  endtask

  // One frame of e system-clock rises; word clock high for the first e cycles.
  task automatic run_frame(input int e, input string tag);
    for (int k = 0; k < 2 * e; k++) begin
      @(negedge clk);
      if (k == 1) chk_all(tag);
      if (k == 0) begin
        if (!m_armed) begin
          m_armed = 1; m_prev = 15; m_valid = 0; m_code = 15;
        end else begin
          int c = classify(m_last);
          if (c != 15 && c == m_prev) begin m_valid = 1; m_code = c; end
          else begin m_valid = 0; m_code = 15; end
          m_prev = c;
        end
        m_ps = 0; m_miss = 0;
      end
      sck  = ~k[0];
      bck  = k[1];
      lrck = (k < e);
    end
    m_last = e;
  endtask

  task automatic idle(input int cycles, input bit s_run, input bit b_run, input bit l_run);
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      if (s_run) sck = ~sck;
      if (b_run && j[0]) bck = ~bck;
      if (l_run && j[7:0] == 8'd0) lrck = ~lrck;
    end
    m_armed = 0; m_prev = 15; m_valid = 0; m_code = 15;
  endtask

  task automatic lock(input int idx, input string tag);
    for (int f = 0; f < 3; f++) run_frame(legal_ratio(idx), tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    // R8: outputs under reset
    chk("R8 code", code, 15); chk("R8 valid", valid, 0);
    chk("R8 missing", missing, 0); chk("R8 power_save", psave, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: first frame discarded, lock after two full frames; R1 code for 256
    run_frame(256, "R3 arm");
    run_frame(256, "R3 one frame");
    run_frame(256, "R3 two frames");
    chk("R1 code 256", code, 3);
    run_frame(256, "R1 hold");
    // R2: tolerance window
    run_frame(258, "R2 plus2");
    run_frame(254, "R2 plus2 closed");
    run_frame(256, "R2 minus2 closed");
    chk("R2 within tolerance", valid, 1);
    run_frame(259, "R2 pre-off3");
    run_frame(256, "R4 off3 closed");
    chk("R4 drop on mismatch", valid, 0);
    run_frame(256, "R4 relock1");
    run_frame(512, "R4 relock2");
    run_frame(512, "R4 change ratio");
    chk("R4 change drops", valid, 0);
    run_frame(512, "R1 512");
    chk("R1 code 512", code, 5);

    // R1 extremes
    lock(11, "R1 3072");
    run_frame(64, "R1 3072 closed");
    chk("R1 code 3072", code, 11);
    lock(0, "R1 64");
    run_frame(192, "R1 64 closed");
    chk("R1 code 64", code, 0);

    // R5: system clock stops, others keep running
    idle(5000, 0, 1, 1);
    @(negedge clk); chk("R5 missing", missing, 1); chk("R5 valid", valid, 0);
    chk("R6 no power_save with clocks", psave, 0);
    lrck = 1'b0; sck = 1'b0;
    run_frame(384, "R5 resume");
    chk("R5 missing cleared", missing, 0);
    run_frame(384, "R5 one");
    run_frame(384, "R5 relock");

    // R6: word clock stopped alone
    idle(5000, 1, 1, 0);
    @(negedge clk); chk("R6 lrck only stopped", psave, 0);
    chk("R6 valid cleared", valid, 0);
    sck = 1'b0;
    run_frame(768, "R6 resume");

    // R6/R7: both stopped, then bit clock alone, then word clock
    idle(5000, 1, 0, 0);
    @(negedge clk); chk("R6 power_save set", psave, 1);
    bck = ~bck;
    @(negedge clk); bck = ~bck;
    @(negedge clk); chk("R7 bck does not release", psave, 1);
    sck = 1'b0;
    m_ps = 1;
    run_frame(1152, "R7 lrck release");
    chk("R7 released", psave, 0);
    m_ps = 0;

    // Random mix
    for (int g = 0; g < 14; g++) begin
      int idx = $urandom_range(0, 7);
      int d   = int'($urandom_range(0, 6)) - 3;
      int nf  = $urandom_range(2, 3);
      for (int f = 0; f < nf; f++) run_frame(legal_ratio(idx) + d, "R2 random");
    end
    run_frame(128, "R4 random close");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule